// File: doc/BRIEF.md
# Cold Redundancy Share-State Controller

Each supply in a redundant bank carries one copy of this controller. The controller decides whether its supply is Active, taking an equal share of the system load, or in Cold Standby, carrying nothing. The host sets the decision in one of two ways. In commanded mode it writes an on/off bit directly. In autonomous mode it hands each supply a unique slot index, and the supply compares a digitized current-share level against the threshold that belongs to its slot. The thresholds rise from slot to slot, so the supplies join the load in a fixed order as demand grows and leave it in reverse as demand falls. A hysteresis margin stops a supply from chattering at its threshold.

A shared emergency line can override either mode. When the line goes high, every supply turns on at once and stays on until the line has been quiet for a debounce time. The controller also keeps a standby supply ready to take load. It closes the ORing switch only when the supply is on. While the supply waits in standby, it briefly pulses the converter output at a fixed period to keep the output capacitors charged.

The debounce time is given in nanoseconds and converted to cycles from the clock frequency parameter. The emergency path has a fixed latency of a few cycles, far inside a 100 us turn-on deadline at any practical clock rate.

Top module: `crr_share_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, `oring_en`, `out_en` and `refresh_pulse` are all 0 and the supply is in standby.
- R2: With `mode_auto`=0 the share state copies `cmd_on` one clock after sampling it. The outputs follow one clock later, and `share_lvl` has no effect.
- R3: With `mode_auto`=1 and `slot_idx`=0 the supply is always Active, whatever `share_lvl` and `cmd_on` are.
- R4: With `mode_auto`=1 and `slot_idx`=n>0, a standby supply becomes Active when `share_lvl` is strictly greater than threshold n. Threshold n is `thr_table[n*SHARE_W +: SHARE_W]`.
- R5: An Active supply in slot n>0 returns to standby only when `share_lvl` + HYST < threshold n. At any level between the two limits it keeps its previous state.
- R6: A high level on `rapid_on_in` drives `oring_en` and `out_en` high within 4 clock cycles, in either mode and from any state.
- R7: The forced-on condition holds while the synchronized `rapid_on_in` is high. It clears only after the synchronized `rapid_on_in` has been low for DEB_CYC consecutive cycles, which is 8 at the default parameters. A high level during the count restarts it.
- R8: While the supply is neither Active nor forced on, `oring_en` is 0. `refresh_pulse` and `out_en` go high for REFRESH_WIDTH cycles out of every REFRESH_PERIOD cycles, with the first pulse starting REFRESH_PERIOD-REFRESH_WIDTH cycles into standby.
- R9: While the supply is Active or forced on, `refresh_pulse` is 0 and the refresh period restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_auto | input | 1 | 1 = autonomous threshold mode, 0 = commanded mode |
| cmd_on | input | 1 | Host on/off command used in commanded mode |
| slot_idx | input | IDX_W | Host-assigned unique slot index |
| share_lvl | input | SHARE_W | Digitized current-share level |
| thr_table | input | SLOTS*SHARE_W | Threshold per slot, slot n in bits n*SHARE_W upward |
| rapid_on_in | input | 1 | Asynchronous emergency turn-on line |
| oring_en | output | 1 | ORing switch enable |
| out_en | output | 1 | Converter output enable (on, or refreshing) |
| refresh_pulse | output | 1 | Capacitor refresh pulse while in standby |

## Verification
The bench probes the threshold boundaries. At a level equal to the threshold, a design using a non-strict compare would wrongly wake up. At a level equal to the threshold minus the margin, an off-by-one hysteresis would drop out early. The bench also bounces the emergency line during the debounce count, which catches a design that never restarts the count and releases too soon. It measures the emergency turn-on latency from the input edge and counts refresh pulses over whole periods. A wrong period or width, or a pulse that escapes while the supply is Active, shows up in those counts. The whole run is also compared, cycle by cycle, against a behavioural model.

// File: rtl/crr_pkg.sv
package crr_pkg;
  typedef enum logic {
    SHARE_STANDBY = 1'b0,
    SHARE_ACTIVE  = 1'b1
  } share_state_e;
endpackage

// File: rtl/crr_rapid_latch.sv
module crr_rapid_latch #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic forced
);
  localparam int DW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic [SYNC_STAGES-1:0] chain;
  logic [DW-1:0]          low_cnt;
  logic                   line_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign line_s = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      forced  <= 1'b0;
      low_cnt <= '0;
    end else if (line_s) begin
      forced  <= 1'b1;
      low_cnt <= '0;
    end else if (forced) begin
      if (low_cnt == DW'(DEB_CYC - 1)) begin
        forced  <= 1'b0;
        low_cnt <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end else begin
      low_cnt <= '0;
    end
  end

  // R6
  sync_sets_force_chk: assert property (@(posedge clk) disable iff (rst)
    line_s |=> forced);
  // R7
  release_only_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(forced) |-> !$past(line_s));
endmodule

// File: rtl/crr_share_decide.sv
module crr_share_decide
  import crr_pkg::*;
#(
  parameter int SHARE_W = 8,
  parameter int SLOTS   = 4,
  parameter int HYST    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_auto,
  input  logic                       cmd_on,
  input  logic [$clog2(SLOTS)-1:0]   slot_idx,
  input  logic [SHARE_W-1:0]         share_lvl,
  input  logic [SLOTS*SHARE_W-1:0]   thr_table,
  output share_state_e               state
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [SHARE_W-1:0] my_thr;
  logic               wake, drop;
  share_state_e       state_d;

  assign my_thr = thr_table[slot_idx*SHARE_W +: SHARE_W];
  assign wake   = share_lvl > my_thr;
  assign drop   = ({1'b0, share_lvl} + (SHARE_W+1)'(HYST)) < {1'b0, my_thr};

  always_comb begin
    state_d = state;
    if (!mode_auto) begin
      state_d = cmd_on ? SHARE_ACTIVE : SHARE_STANDBY;
    end else if (slot_idx == IDX_W'(0)) begin
      state_d = SHARE_ACTIVE;
    end else if (state == SHARE_STANDBY && wake) begin
      state_d = SHARE_ACTIVE;
    end else if (state == SHARE_ACTIVE && drop) begin
      state_d = SHARE_STANDBY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SHARE_STANDBY;
    else     state <= state_d;
  end

  // R2
  cmd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_auto |=> (state == SHARE_ACTIVE) == $past(cmd_on));
  // R3
  slot_zero_on_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_auto && slot_idx == IDX_W'(0)) |=> state == SHARE_ACTIVE);
endmodule

// File: rtl/crr_refresh_timer.sv
module crr_refresh_timer #(
  parameter int PERIOD = 32,
  parameter int WIDTH  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic in_window
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold)                  cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))  cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign in_window = !hold && (cnt >= CW'(PERIOD - WIDTH));
endmodule

// File: rtl/crr_share_ctrl.sv
module crr_share_ctrl
  import crr_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int SHARE_W        = 8,
  parameter int SLOTS          = 4,
  parameter int HYST           = 4,
  parameter int DEBOUNCE_NS    = 160,
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_PERIOD = 32,
  parameter int REFRESH_WIDTH  = 3,
  localparam int IDX_W         = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_auto,
  input  logic                     cmd_on,
  input  logic [IDX_W-1:0]         slot_idx,
  input  logic [SHARE_W-1:0]       share_lvl,
  input  logic [SLOTS*SHARE_W-1:0] thr_table,
  input  logic                     rapid_on_in,
  output logic                     oring_en,
  output logic                     out_en,
  output logic                     refresh_pulse
);
  localparam int DEB_RAW = (CLK_HZ / 1000) * DEBOUNCE_NS / 1_000_000;
  localparam int DEB_CYC = (DEB_RAW < 1) ? 1 : DEB_RAW;

  share_state_e state;
  logic         forced, eff_on, window;

  crr_rapid_latch #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_rapid (
    .clk(clk), .rst(rst), .line_in(rapid_on_in), .forced(forced)
  );

  crr_share_decide #(.SHARE_W(SHARE_W), .SLOTS(SLOTS), .HYST(HYST)) u_decide (
    .clk(clk), .rst(rst), .mode_auto(mode_auto), .cmd_on(cmd_on),
    .slot_idx(slot_idx), .share_lvl(share_lvl), .thr_table(thr_table),
    .state(state)
  );

  assign eff_on = (state == SHARE_ACTIVE) || forced;

  crr_refresh_timer #(.PERIOD(REFRESH_PERIOD), .WIDTH(REFRESH_WIDTH)) u_refresh (
    .clk(clk), .rst(rst), .hold(eff_on), .in_window(window)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oring_en      <= 1'b0;
      out_en        <= 1'b0;
      refresh_pulse <= 1'b0;
    end else begin
      oring_en      <= eff_on;
      out_en        <= eff_on || window;
      refresh_pulse <= window;
    end
  end

  // R6
  forced_drives_out_chk: assert property (@(posedge clk) disable iff (rst)
    forced |=> (oring_en && out_en));
  // R9
  no_refresh_when_on_chk: assert property (@(posedge clk) disable iff (rst)
    $past(state == SHARE_ACTIVE) |-> !refresh_pulse);
  // R8
  standby_oring_off_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_pulse |-> (!oring_en && out_en));
endmodule

// File: tb/sim_crr_share_ctrl.sv
module sim_crr_share_ctrl;
  localparam int SW = 8;
  localparam int NS = 4;
  localparam int HY = 4;
  localparam int DEB = 8;
  localparam int PER = 32;
  localparam int WID = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_auto = 1'b0;
  logic cmd_on = 1'b0;
  logic [1:0] slot_idx = 2'd0;
  logic [SW-1:0] share_lvl = '0;
  logic [NS*SW-1:0] thr_table = {8'd200, 8'd100, 8'd50, 8'd0};
  logic rapid_on_in = 1'b0;
  logic oring_en, out_en, refresh_pulse;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  crr_share_ctrl u0 (
    .clk(clk), .rst(rst), .mode_auto(mode_auto), .cmd_on(cmd_on),
    .slot_idx(slot_idx), .share_lvl(share_lvl), .thr_table(thr_table),
    .rapid_on_in(rapid_on_in), .oring_en(oring_en), .out_en(out_en),
    .refresh_pulse(refresh_pulse)
  );

  // behavioural reference
  int m_s1, m_s2, m_frc, m_low, m_act, m_cnt, m_or, m_out, m_ref;
  initial begin
    m_s1 = 0; m_s2 = 0; m_frc = 0; m_low = 0; m_act = 0;
    m_cnt = 0; m_or = 0; m_out = 0; m_ref = 0;
  end

  always @(posedge clk) begin
    int on_old, thr, n_frc, n_low, n_act, n_cnt, n_ref;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_frc = 0; m_low = 0; m_act = 0;
      m_cnt = 0; m_or = 0; m_out = 0; m_ref = 0;
    end else begin
      on_old = (m_act != 0 || m_frc != 0) ? 1 : 0;
      n_frc = m_frc; n_low = 0;
      if (m_s2 != 0) begin n_frc = 1; n_low = 0; end
      else if (m_frc != 0) begin
        if (m_low + 1 >= DEB) begin n_frc = 0; n_low = 0; end
        else n_low = m_low + 1;
      end
      thr = int'(thr_table[int'(slot_idx)*SW +: SW]);
      n_act = m_act;
      if (!mode_auto) n_act = cmd_on ? 1 : 0;
      else if (slot_idx == 0) n_act = 1;
      else if (m_act == 0 && int'(share_lvl) > thr) n_act = 1;
      else if (m_act != 0 && int'(share_lvl) + HY < thr) n_act = 0;
      n_cnt = (on_old != 0) ? 0 : ((m_cnt + 1) % PER);
      n_ref = (on_old == 0 && m_cnt >= PER - WID) ? 1 : 0;
      m_or = on_old;
      m_out = (on_old != 0 || n_ref != 0) ? 1 : 0;
      m_ref = n_ref;
      m_cnt = n_cnt; m_act = n_act; m_frc = n_frc; m_low = n_low;
      m_s2 = m_s1; m_s1 = rapid_on_in ? 1 : 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model oring_en", int'(oring_en), m_or);
      chk(cur_req, "model out_en", int'(out_en), m_out);
      chk(cur_req, "model refresh_pulse", int'(refresh_pulse), m_ref);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (refresh_pulse) cnt++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pc, lat;
    cyc(5);
    chk("R1", "oring_en in reset", int'(oring_en), 0);
    chk("R1", "refresh_pulse in reset", int'(refresh_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "oring_en after reset", int'(oring_en), 0);
    chk("R1", "out_en after reset", int'(out_en), 0);

    cur_req = "R2";
    cmd_on = 1'b1; cyc(3);
    chk("R2", "commanded on", int'(oring_en), 1);
    share_lvl = 8'd0; mode_auto = 1'b0; cyc(3);
    chk("R2", "share ignored in commanded mode", int'(oring_en), 1);
    cur_req = "R9";
    count_pulses(2*PER, pc);
    chk("R9", "no refresh while active", pc, 0);
    cur_req = "R2";
    share_lvl = 8'd255; cmd_on = 1'b0; cyc(3);
    chk("R2", "commanded off, high share ignored", int'(oring_en), 0);

    cur_req = "R8";
    cmd_on = 1'b0; cyc(1);
    count_pulses(2*PER, pc);
    chk("R8", "refresh pulse cycles over two periods", pc, 2*WID);
    chk("R8", "oring held off in standby", int'(oring_en), 0);

    cur_req = "R3";
    mode_auto = 1'b1; slot_idx = 2'd0; share_lvl = 8'd0; cmd_on = 1'b0; cyc(3);
    chk("R3", "slot 0 active with zero share", int'(oring_en), 1);

    cur_req = "R4";
    slot_idx = 2'd2; share_lvl = 8'd0; cyc(3);
    chk("R4", "slot 2 drops at zero share", int'(oring_en), 0);
    share_lvl = 8'd100; cyc(4);
    chk("R4", "share equal to threshold stays standby", int'(oring_en), 0);
    share_lvl = 8'd101; cyc(3);
    chk("R4", "share above threshold wakes", int'(oring_en), 1);

    cur_req = "R5";
    share_lvl = 8'd97; cyc(4);
    chk("R5", "inside hysteresis band stays active", int'(oring_en), 1);
    share_lvl = 8'd96; cyc(4);
    chk("R5", "at band floor stays active", int'(oring_en), 1);
    share_lvl = 8'd95; cyc(3);
    chk("R5", "below band floor drops", int'(oring_en), 0);
    share_lvl = 8'd99; cyc(4);
    chk("R5", "back in band from standby stays off", int'(oring_en), 0);
    slot_idx = 2'd1; cyc(3);
    chk("R4", "slot 1 threshold 50 wakes at 99", int'(oring_en), 1);

    cur_req = "R6";
    slot_idx = 2'd3; share_lvl = 8'd10; cyc(4);
    chk("R6", "slot 3 standby before rapid", int'(oring_en), 0);
    rapid_on_in = 1'b1;
    lat = 0;
    while (!oring_en && lat < 10) begin @(negedge clk); lat++; end
    chk("R6", "rapid latency within 4", (lat <= 4) ? 1 : 0, 1);
    chk("R6", "out_en forced", int'(out_en), 1);

    cur_req = "R7";
    cyc(5);
    rapid_on_in = 1'b0; cyc(5);
    rapid_on_in = 1'b1; cyc(1);
    rapid_on_in = 1'b0; cyc(8);
    chk("R7", "bounce restarts debounce", int'(oring_en), 1);
    cyc(6);
    chk("R7", "released after debounce", int'(oring_en), 0);

    cur_req = "R6";
    mode_auto = 1'b0; cmd_on = 1'b0; cyc(2);
    rapid_on_in = 1'b1; cyc(4);
    chk("R6", "rapid forces on in commanded mode", int'(oring_en), 1);
    rapid_on_in = 1'b0;
    cur_req = "R7";
    cyc(20);
    chk("R7", "commanded off after release", int'(oring_en), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule